// File: doc/BRIEF.md
# Column-Parallel Cluster Finder and Sparsifier

The block receives one full row of pixel samples per row strobe, one 5-bit unsigned code per column, all columns in parallel. Each new row is paired with the row before it. Every square of two adjacent columns by these two rows forms a kernel, and the four samples in a kernel are summed. A kernel whose sum lies above its threshold is a hit. A hit marks a window around itself for readout: the two kernel rows, the row before them and the row after them, across the kernel's left column and four columns on either side. The window is clipped at the edges of the array. Windows that overlap are merged, so a pixel is flagged at most once.

A row is final once no later row can flag it, which is two row strobes after it arrives. Each final row that has at least one flagged pixel enters a small queue of rows. A sparsifier takes the flagged pixels out of the queue one per cycle, in increasing column order, and presents each as a (row, column, value) word on a valid/ready output. Rows leave in the order they arrived. The input is never stalled. When a flagged row is ready and the queue is full, that row is dropped and a sticky overflow flag is raised.

Thresholds come either from one global value or from one value per kernel position, which allows gain differences between columns to be corrected. A mode input selects between the two. A frame has a fixed number of rows. The row counter wraps at the end of a frame, and the last two rows of a frame are released in the two cycles after the frame's final strobe.

Top module: `cluster_sparsifier`

## Requirements
- R1: After reset, outValid is 0 and overflow is 0.
- R2: With thrMode = 0, a kernel is a hit exactly when the 7-bit sum of its four samples is strictly greater than thrGlobal. A sum equal to the threshold is not a hit.
- R3: With thrMode = 1, a kernel whose left column is c uses threshold field c of thrCols, which occupies bits [7c+6:7c]. The strict-greater rule of R2 still applies.
- R4: A hit found at row strobe r, with left column c, flags rows r-2 to r+1 and columns c-4 to c+4. Rows outside 0..NROWS-1 and columns outside 0..NCOLS-1 are ignored. The strobe of row 0 forms no kernel.
- R5: Overlapping windows are merged. Each flagged pixel of a frame is output exactly once, and pixels that are not flagged are never output.
- R6: Each output word carries outRow (the row index in the frame), outCol (the column index) and outPix (the sample value of that pixel). Rows leave in arrival order, and within a row the columns leave in increasing order.
- R7: While outValid is 1 and outReady is 0, outValid stays 1 and outRow, outCol and outPix do not change. A word is transferred on a clock edge where outValid and outReady are both 1.
- R8: The row queue holds up to BUF_DEPTH rows that have at least one flagged pixel. Rows with no flagged pixel take no space. A flagged row that finds the queue full is dropped whole. This sets overflow, which stays 1 until reset. The input is never stalled.
- R9: A frame is NROWS row strobes. The row index wraps to 0 after row NROWS-1, and the final two rows are released without further strobes. A row strobe is a one-cycle pulse, and no strobe may come in the two cycles after the last row of a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rowValid | input | 1 | One-cycle strobe: rowData holds a new row |
| rowData | input | NCOLS*PIX_W | Row samples, column c at bits [5c+4:5c] |
| thrMode | input | 1 | 0: global threshold, 1: per-kernel thresholds |
| thrGlobal | input | PIX_W+2 | Global kernel threshold |
| thrCols | input | (NCOLS-1)*(PIX_W+2) | Threshold per kernel left column |
| outValid | output | 1 | Output word valid |
| outReady | input | 1 | Consumer accepts the word |
| outRow | output | clog2(NROWS) | Row index of the output pixel |
| outCol | output | clog2(NCOLS) | Column index of the output pixel |
| outPix | output | PIX_W | Sample value of the output pixel |
| overflow | output | 1 | Sticky: a flagged row was dropped |

## Verification
Random sparse frames are run on a low background with injected 2×2 clusters of varying strength, under both threshold modes and with the consumer either always ready or ready on every other cycle. Together these separate kernel summing and thresholding errors from window placement and ordering errors. Directed frames cover the following cases: a sum exactly equal to the threshold, one higher than it, clusters at the corners of the array where the window must be clipped, windows that overlap and must merge, and per-column thresholds that suppress one cluster while a neighbouring column admits another. A final frame holds the output off while many rows are flagged. It checks that exactly the first BUF_DEPTH flagged rows survive and that the overflow flag rises. Frames run back to back without reset, which exercises the wrap of the row counter.

// File: rtl/cs_pkg.sv
package cs_pkg;
  typedef struct packed {
    logic advance;    // shift the row pipeline
    logic takeInput;  // load rowData as the newest row
    logic kernelEn;   // kernels valid this cycle
    logic pushEn;     // oldest held row is final
    logic lastRow;    // current strobe ends the frame
  } ctrl_strobe_t;
endpackage

// File: rtl/cs_ctrl.sv
module cs_ctrl
  import cs_pkg::*;
#(
  parameter int NROWS = 32,
  localparam int ROW_W = $clog2(NROWS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rowValid,
  output ctrl_strobe_t     strobe,
  output logic [ROW_W-1:0] pushRow
);
  typedef enum logic [1:0] {ST_IDLE, ST_FLUSH1, ST_FLUSH2} state_t;

  state_t           state;
  logic [ROW_W-1:0] rowCnt;
  logic             isLast;

  assign isLast = (rowCnt == ROW_W'(NROWS - 1));

  always_comb begin
    strobe  = '0;
    pushRow = '0;
    case (state)
      ST_IDLE: if (rowValid) begin
        strobe.advance   = 1'b1;
        strobe.takeInput = 1'b1;
        strobe.kernelEn  = (rowCnt != '0);
        strobe.pushEn    = (rowCnt >= ROW_W'(2));
        strobe.lastRow   = isLast;
        pushRow          = rowCnt - ROW_W'(2);
      end
      ST_FLUSH1: begin
        strobe.advance = 1'b1;
        strobe.pushEn  = 1'b1;
        pushRow        = ROW_W'(NROWS - 2);
      end
      default: begin
        strobe.advance = 1'b1;
        strobe.pushEn  = 1'b1;
        pushRow        = ROW_W'(NROWS - 1);
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      rowCnt <= '0;
    end else begin
      case (state)
        ST_IDLE: if (rowValid) begin
          rowCnt <= isLast ? '0 : rowCnt + ROW_W'(1);
          state  <= isLast ? ST_FLUSH1 : ST_IDLE;
        end
        ST_FLUSH1: state <= ST_FLUSH2;
        default:   state <= ST_IDLE;
      endcase
    end
  end

  AST_NO_ROW_IN_FLUSH: assert property (@(posedge clk) disable iff (!rstN)
    (state != ST_IDLE) |-> !rowValid); // R9
endmodule

// File: rtl/cs_datapath.sv
module cs_datapath
  import cs_pkg::*;
#(
  parameter int NCOLS    = 16,
  parameter int PIX_W    = 5,
  parameter int WIN_HALF = 4,
  localparam int SUM_W = PIX_W + 2
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  ctrl_strobe_t                   strobe,
  input  logic [NCOLS*PIX_W-1:0]         rowData,
  input  logic                           thrMode,
  input  logic [SUM_W-1:0]               thrGlobal,
  input  logic [(NCOLS-1)*SUM_W-1:0]     thrCols,
  output logic                           pushEn,
  output logic [NCOLS-1:0]               pushMask,
  output logic [NCOLS*PIX_W-1:0]         pushData
);
  logic [NCOLS*PIX_W-1:0] rowPrev, rowOld;
  logic [NCOLS-1:0]       maskOld, maskPrev, maskNext;
  logic [NCOLS-2:0]       hits;
  logic [NCOLS-1:0]       win;

  for (genvar c = 0; c < NCOLS - 1; c++) begin : g_kern
    logic [SUM_W-1:0] kSum, kThr;
    assign kSum = SUM_W'(rowPrev[c*PIX_W +: PIX_W]) + SUM_W'(rowPrev[(c+1)*PIX_W +: PIX_W])
                + SUM_W'(rowData[c*PIX_W +: PIX_W]) + SUM_W'(rowData[(c+1)*PIX_W +: PIX_W]);
    assign kThr = thrMode ? thrCols[c*SUM_W +: SUM_W] : thrGlobal;
    assign hits[c] = strobe.kernelEn && (kSum > kThr);
  end

  for (genvar j = 0; j < NCOLS; j++) begin : g_spread
    logic acc;
    always_comb begin
      acc = 1'b0;
      for (int c = 0; c < NCOLS - 1; c++)
        if (c >= j - WIN_HALF && c <= j + WIN_HALF) acc = acc | hits[c];
    end
    assign win[j] = acc;
  end

  assign pushEn   = strobe.pushEn;
  assign pushMask = maskOld | win;
  assign pushData = rowOld;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      maskOld  <= '0;
      maskPrev <= '0;
      maskNext <= '0;
      rowOld   <= '0;
      rowPrev  <= '0;
    end else if (strobe.advance) begin
      rowOld   <= rowPrev;
      maskOld  <= maskPrev | win;
      maskPrev <= maskNext | win;
      maskNext <= (strobe.takeInput && !strobe.lastRow) ? win : '0;
      if (strobe.takeInput) rowPrev <= rowData;
    end
  end

  AST_FRAME_START_CLEAN: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.takeInput && !strobe.kernelEn) |-> (maskOld == '0 && maskPrev == '0 && maskNext == '0)); // R9
endmodule

// File: rtl/cs_rowq.sv
module cs_rowq #(
  parameter int NCOLS = 16,
  parameter int PIX_W = 5,
  parameter int NROWS = 32,
  parameter int DEPTH = 4,
  localparam int ROW_W = $clog2(NROWS),
  localparam int COL_W = $clog2(NCOLS),
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   pushEn,
  input  logic [ROW_W-1:0]       pushRow,
  input  logic [NCOLS-1:0]       pushMask,
  input  logic [NCOLS*PIX_W-1:0] pushData,
  input  logic                   outReady,
  output logic                   outValid,
  output logic [ROW_W-1:0]       outRow,
  output logic [COL_W-1:0]       outCol,
  output logic [PIX_W-1:0]       outPix,
  output logic                   overflow
);
  logic [ROW_W-1:0]       qRow  [DEPTH];
  logic [NCOLS-1:0]       qMask [DEPTH];
  logic [NCOLS*PIX_W-1:0] qData [DEPTH];
  logic [PTR_W-1:0]       rdPtr, wrPtr;
  logic [CNT_W-1:0]       count;

  logic [NCOLS-1:0] headMask, remMask;
  logic [COL_W-1:0] lowIdx;
  logic             isFull, emit, doPop, doPush, flagged;
  logic             contValid;
  logic [COL_W-1:0] contCol;

  function automatic logic [PTR_W-1:0] ptrNext(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  always_comb begin
    headMask = qMask[rdPtr];
    lowIdx   = '0;
    for (int c = NCOLS - 1; c >= 0; c--)
      if (headMask[c]) lowIdx = COL_W'(c);
    remMask         = headMask;
    remMask[lowIdx] = 1'b0;
  end

  assign flagged = pushEn && (pushMask != '0);
  assign isFull  = (count == CNT_W'(DEPTH));
  assign emit    = (count != '0) && (!outValid || outReady);
  assign doPop   = emit && (remMask == '0);
  assign doPush  = flagged && !isFull;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdPtr     <= '0;
      wrPtr     <= '0;
      count     <= '0;
      outValid  <= 1'b0;
      outRow    <= '0;
      outCol    <= '0;
      outPix    <= '0;
      overflow  <= 1'b0;
      contValid <= 1'b0;
      contCol   <= '0;
      for (int i = 0; i < DEPTH; i++) qMask[i] <= '0;
    end else begin
      if (emit) begin
        outValid     <= 1'b1;
        outRow       <= qRow[rdPtr];
        outCol       <= lowIdx;
        outPix       <= qData[rdPtr][int'(lowIdx)*PIX_W +: PIX_W];
        qMask[rdPtr] <= remMask;
        contValid    <= !doPop;
        contCol      <= lowIdx;
        if (doPop) rdPtr <= ptrNext(rdPtr);
      end else if (outReady) begin
        outValid <= 1'b0;
      end
      if (doPush) begin
        qRow[wrPtr]  <= pushRow;
        qMask[wrPtr] <= pushMask;
        qData[wrPtr] <= pushData;
        wrPtr        <= ptrNext(wrPtr);
      end
      if (flagged && isFull) overflow <= 1'b1;
      case ({doPush, doPop})
        2'b10:   count <= count + CNT_W'(1);
        2'b01:   count <= count - CNT_W'(1);
        default: count <= count;
      endcase
    end
  end

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outRow) && $stable(outCol) && $stable(outPix))); // R7
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    overflow |=> overflow); // R8
  AST_COUNT_LIMIT: assert property (@(posedge clk) disable iff (!rstN)
    count <= CNT_W'(DEPTH)); // R8
  AST_COL_RISING: assert property (@(posedge clk) disable iff (!rstN)
    (emit && contValid) |-> (lowIdx > contCol)); // R6
endmodule

// File: rtl/cluster_sparsifier.sv
module cluster_sparsifier
  import cs_pkg::*;
#(
  parameter int NCOLS     = 16,
  parameter int NROWS     = 32,
  parameter int PIX_W     = 5,
  parameter int BUF_DEPTH = 4,
  parameter int WIN_HALF  = 4,
  localparam int SUM_W = PIX_W + 2,
  localparam int ROW_W = $clog2(NROWS),
  localparam int COL_W = $clog2(NCOLS)
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       rowValid,
  input  logic [NCOLS*PIX_W-1:0]     rowData,
  input  logic                       thrMode,
  input  logic [SUM_W-1:0]           thrGlobal,
  input  logic [(NCOLS-1)*SUM_W-1:0] thrCols,
  output logic                       outValid,
  input  logic                       outReady,
  output logic [ROW_W-1:0]           outRow,
  output logic [COL_W-1:0]           outCol,
  output logic [PIX_W-1:0]           outPix,
  output logic                       overflow
);
  ctrl_strobe_t           strobe;
  logic [ROW_W-1:0]       pushRow;
  logic                   pushEn;
  logic [NCOLS-1:0]       pushMask;
  logic [NCOLS*PIX_W-1:0] pushData;

  cs_ctrl #(.NROWS(NROWS)) ctrl_i (
    .clk(clk), .rstN(rstN), .rowValid(rowValid), .strobe(strobe), .pushRow(pushRow)
  );

  cs_datapath #(.NCOLS(NCOLS), .PIX_W(PIX_W), .WIN_HALF(WIN_HALF)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .rowData(rowData), .thrMode(thrMode),
    .thrGlobal(thrGlobal), .thrCols(thrCols), .pushEn(pushEn), .pushMask(pushMask),
    .pushData(pushData)
  );

  cs_rowq #(.NCOLS(NCOLS), .PIX_W(PIX_W), .NROWS(NROWS), .DEPTH(BUF_DEPTH)) rowq_i (
    .clk(clk), .rstN(rstN), .pushEn(pushEn), .pushRow(pushRow), .pushMask(pushMask),
    .pushData(pushData), .outReady(outReady), .outValid(outValid), .outRow(outRow),
    .outCol(outCol), .outPix(outPix), .overflow(overflow)
  );
endmodule

// File: tb/cluster_sparsifier_tb_top.sv
module cluster_sparsifier_tb_top;
  localparam int NCOLS = 16;
  localparam int NROWS = 32;
  localparam int PIX_W = 5;
  localparam int DEPTH = 4;
  localparam int HALF  = 4;
  localparam int SUM_W = PIX_W + 2;
  localparam int ROW_W = $clog2(NROWS);
  localparam int COL_W = $clog2(NCOLS);
  localparam int GAP   = 40;
  // vector fields: [31:16] seed, [15:12] clusters, [11:10] ready mode, [9] thrMode, [6:0] thrGlobal
  localparam logic [31:0] VEC [6] = '{
    32'h1A2B_3014, 32'h5C3D_6018, 32'h0F1E_8414, 32'h7777_5216, 32'h2468_A618, 32'h1357_F014
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic rowValid = 1'b0;
  logic [NCOLS*PIX_W-1:0] rowData = '0;
  logic thrMode = 1'b0;
  logic [SUM_W-1:0] thrGlobal = SUM_W'(20);
  logic [(NCOLS-1)*SUM_W-1:0] thrColsV = '0;
  logic outValid, outReady;
  logic [ROW_W-1:0] outRow;
  logic [COL_W-1:0] outCol;
  logic [PIX_W-1:0] outPix;
  logic overflow;

  always #4 clk = ~clk;

  cluster_sparsifier #(.NCOLS(NCOLS), .NROWS(NROWS), .PIX_W(PIX_W), .BUF_DEPTH(DEPTH),
                       .WIN_HALF(HALF)) dut_i (
    .clk(clk), .rstN(rstN), .rowValid(rowValid), .rowData(rowData), .thrMode(thrMode),
    .thrGlobal(thrGlobal), .thrCols(thrColsV), .outValid(outValid), .outReady(outReady),
    .outRow(outRow), .outCol(outCol), .outPix(outPix), .overflow(overflow)
  );

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;
  int pix [NROWS][NCOLS];
  int thrCol [NCOLS];
  int expRow [NROWS*NCOLS];
  int expCol [NROWS*NCOLS];
  int expPix [NROWS*NCOLS];
  int expN = 0;
  int gotIdx = 0;
  int readyMode = 0;
  string curTag = "R5";
  logic [31:0] rs = 32'h1;
  bit stallPrev = 1'b0;
  logic [ROW_W+COL_W+PIX_W-1:0] savedWord;

  function automatic logic [31:0] xs(input logic [31:0] s);
    logic [31:0] t;
    t = s ^ (s << 13);
    t = t ^ (t >> 17);
    return t ^ (t << 5);
  endfunction

  function automatic int rnd(input int m);
    rs = xs(rs);
    return int'(rs[15:0]) % m;
  endfunction

  task automatic check(input string tag, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic clearFrame();
    for (int r = 0; r < NROWS; r++) for (int c = 0; c < NCOLS; c++) pix[r][c] = 0;
  endtask

  task automatic inject(input int r, input int c, input int v);
    pix[r][c] = v; pix[r][c+1] = v; pix[r+1][c] = v; pix[r+1][c+1] = v;
  endtask

  task automatic applyThr();
    for (int c = 0; c < NCOLS - 1; c++) thrColsV[c*SUM_W +: SUM_W] = SUM_W'(thrCol[c]);
  endtask

  // reference: flagged set from the requirements, first 'limit' flagged rows kept
  task automatic buildExpected(input int limit);
    bit mark [NROWS][NCOLS];
    int sum, thr, kept;
    bit any;
    for (int r = 0; r < NROWS; r++) for (int c = 0; c < NCOLS; c++) mark[r][c] = 1'b0;
    for (int r = 1; r < NROWS; r++)
      for (int c = 0; c < NCOLS - 1; c++) begin
        sum = pix[r-1][c] + pix[r-1][c+1] + pix[r][c] + pix[r][c+1];
        thr = thrMode ? thrCol[c] : int'(thrGlobal);
        if (sum > thr)
          for (int wr = r - 2; wr <= r + 1; wr++)
            for (int wc = c - HALF; wc <= c + HALF; wc++)
              if (wr >= 0 && wr < NROWS && wc >= 0 && wc < NCOLS) mark[wr][wc] = 1'b1;
      end
    expN = 0; kept = 0;
    for (int r = 0; r < NROWS; r++) begin
      any = 1'b0;
      for (int c = 0; c < NCOLS; c++) any |= mark[r][c];
      if (any && kept < limit) begin
        kept++;
        for (int c = 0; c < NCOLS; c++)
          if (mark[r][c]) begin
            expRow[expN] = r; expCol[expN] = c; expPix[expN] = pix[r][c]; expN++;
          end
      end
    end
  endtask

  task automatic sendRow(input int r);
    @(negedge clk);
    for (int c = 0; c < NCOLS; c++) rowData[c*PIX_W +: PIX_W] = PIX_W'(pix[r][c]);
    rowValid = 1'b1;
    @(negedge clk);
    rowValid = 1'b0;
    repeat (GAP - 1) @(negedge clk);
  endtask

  task automatic runFrame(input string tag, input int limit, input int rdy);
    buildExpected(limit);
    curTag = tag;
    gotIdx = 0;
    readyMode = rdy;
    for (int r = 0; r < NROWS; r++) sendRow(r);
    if (rdy == 2) begin
      repeat (20) @(negedge clk);
      readyMode = 0;
    end
    repeat (200) @(negedge clk);
    check(tag, gotIdx, expN, "word count of frame");
  endtask

  // output collector: handshake words compared in order; stalled words must hold
  always @(negedge clk) begin
    if (!rstN) begin
      outReady = 1'b0;
      stallPrev = 1'b0;
    end else begin
      if (stallPrev) begin
        checks++;
        if ({outRow, outCol, outPix} != savedWord || !outValid) begin
          failures++;
          $display("FAIL R7 stalled word changed actual=%h expected=%h", {outRow, outCol, outPix}, savedWord);
        end
      end
      case (readyMode)
        0:       outReady = 1'b1;
        1:       outReady = ~outReady;
        default: outReady = 1'b0;
      endcase
      stallPrev = outValid && !outReady;
      savedWord = {outRow, outCol, outPix};
      if (outValid && outReady) begin
        checks++;
        if (gotIdx >= expN) begin
          failures++;
          $display("FAIL %s extra word actual=r%0d c%0d v%0d expected=none", curTag, outRow, outCol, outPix);
        end else if (int'(outRow) != expRow[gotIdx] || int'(outCol) != expCol[gotIdx] ||
                     int'(outPix) != expPix[gotIdx]) begin
          failures++;
          $display("FAIL %s word %0d actual=r%0d c%0d v%0d expected=r%0d c%0d v%0d", curTag, gotIdx,
                   outRow, outCol, outPix, expRow[gotIdx], expCol[gotIdx], expPix[gotIdx]);
        end
        gotIdx++;
      end
    end
  end

  task automatic finishRun();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    finishRun();
  end

  initial begin
    for (int c = 0; c < NCOLS; c++) thrCol[c] = 20;
    applyThr();
    repeat (4) @(negedge clk);
    // R1: reset state
    check("R1", int'(outValid), 0, "outValid after reset");
    check("R1", int'(overflow), 0, "overflow after reset");
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    check("R1", int'(outValid), 0, "outValid idle");

    // random frames from the vector table; frames run back to back (R9 wrap)
    for (int v = 0; v < 6; v++) begin
      rs = {16'h9E37, VEC[v][31:16]};
      thrMode = VEC[v][9];
      thrGlobal = VEC[v][6:0];
      for (int c = 0; c < NCOLS; c++) thrCol[c] = 14 + (c % 5) * 3;
      applyThr();
      for (int r = 0; r < NROWS; r++) for (int c = 0; c < NCOLS; c++) pix[r][c] = rnd(4);
      for (int k = 0; k < int'(VEC[v][15:12]); k++)
        inject(rnd(NROWS - 1), rnd(NCOLS - 1), 4 + rnd(9));
      runFrame(VEC[v][9] ? "R3" : (v == 0 ? "R2" : "R9"), NROWS, int'(VEC[v][11:10]));
    end

    // R2: sum equal to threshold is no hit, one above is a hit
    thrMode = 1'b0; thrGlobal = SUM_W'(20);
    clearFrame(); inject(5, 7, 5);
    runFrame("R2", NROWS, 0);
    check("R2", expN, 0, "reference words for sum equal to threshold");
    clearFrame(); inject(5, 7, 5); pix[6][8] = 6;
    runFrame("R2", NROWS, 0);
    check("R2", expN, 4 * 9, "reference words for sum above threshold");

    // R4: clipping at array corners
    clearFrame(); inject(0, 0, 9); inject(NROWS - 2, NCOLS - 2, 9);
    runFrame("R4", NROWS, 0);

    // R5: close-spaced overlapping windows merge
    clearFrame(); inject(10, 3, 8); inject(10, 7, 8); inject(12, 5, 8); inject(13, 6, 7);
    runFrame("R5", NROWS, 1);

    // R3: per-column thresholds, one cluster suppressed, another admitted
    thrMode = 1'b1;
    for (int c = 0; c < NCOLS; c++) thrCol[c] = 20;
    thrCol[3] = 60; thrCol[10] = 35;
    applyThr();
    clearFrame(); inject(8, 3, 10); inject(20, 10, 9);
    runFrame("R3", NROWS, 0);
    check("R3", expN, 4 * 9, "reference words for per-column case");

    // R6: ordering over many rows with a slow consumer
    thrMode = 1'b0;
    clearFrame(); inject(2, 12, 9); inject(3, 1, 9); inject(17, 6, 9);
    runFrame("R6", NROWS, 1);

    // R8: consumer held off, queue fills, later flagged rows dropped
    clearFrame(); inject(2, 2, 9); inject(9, 8, 9); inject(16, 4, 9); inject(23, 11, 9);
    runFrame("R8", DEPTH, 2);
    check("R8", int'(overflow), 1, "sticky overflow after drops");
    repeat (10) @(negedge clk);
    check("R8", int'(overflow), 1, "overflow still set");
    finishRun();
  end
endmodule